// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps wall-clock time and calendar date in seven byte-wide registers, each holding packed BCD. The registers are seconds, minutes, hours, date of month, month, weekday and a two-digit year standing for 2000 to 2099. A reference enable arrives at 32.768 kHz. A prescaler turns it into a one-second step, and that step ripples carries from seconds up to the year. The ripple handles short months and leap-year Februaries.

Software sets the time through a simple synchronous write port and reads it back through a registered read port. The hours register has two meanings, chosen by its top bit: a 24-hour count, or a 12-hour count with an afternoon flag. The top bit of the seconds register stops the clock.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the registers read seconds 0x00, minutes 0x00, hours 0x00 (24-hour), date 0x01, month 0x01, weekday 0x01, year 0x00, and counting is enabled.
- R2: Seconds and minutes count in BCD from 00 to 59. A step from 59 returns the field to 00 and advances the next field; a units digit of 9 carries into the tens digit (09 becomes 10).
- R3: With hours bit 7 = 0 (24-hour), bits 5:0 hold BCD 00 to 23. The step from 23 goes to 00 and advances the date; 19 goes to 20.
- R4: With hours bit 7 = 1 (12-hour), bits 4:0 hold BCD 01 to 12 and bit 5 is the afternoon flag (1 = PM). Stepping from 11 gives 12 and inverts the flag; stepping from 12 gives 01 and keeps the flag. Only the 11 PM to 12 AM step advances the date.
- R5: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February. February ends after 29 in leap years and after 28 otherwise. Each wrap advances the month.
- R6: A year value is a leap year exactly when it is divisible by four, 00 included.
- R7: Month 12 wraps to 01 and advances the year; year 99 wraps to 00.
- R8: The weekday advances with every date step and wraps from 7 to 1.
- R9: Seconds bit 7 is a halt flag. While it is 1 no field changes, however many reference enables arrive. Writing it to 0 resumes counting.
- R10: One second elapses per DIV reference enables. A write to the seconds register restarts the count of enables from zero.
- R11: Register addresses are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 weekday, 6 year. Read data appears on the clock edge after the address is presented. Address 7 reads 0x00 and writes to it change nothing. Bits with no meaning (hours bit 6, weekday bits 7:3, and so on) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference enable at 32.768 kHz, one clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data, packed BCD with control bits |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Registered read data |

## Verification
A wrong carry condition shows up at the ports as a field that overshoots its range or fails to advance its neighbour. This is visible on the first second that crosses the boundary, so every vector loads the time just before a boundary and steps exactly one second. A prescaler fault shifts when the seconds register changes. The bench therefore counts reference enables to the exact step, and also the step before it, after a seconds write. A halt fault shows as any field moving while the flag is set.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 8;

  typedef enum logic [REG_AW-1:0] {
    A_SEC  = 3'd0,
    A_MIN  = 3'd1,
    A_HOUR = 3'd2,
    A_DATE = 3'd3,
    A_MON  = 3'd4,
    A_WDAY = 3'd5,
    A_YEAR = 3'd6,
    A_NONE = 3'd7
  } reg_addr_e;

  // bits that hold meaning in each register
  localparam logic [7:0] M_SEC  = 8'hFF;
  localparam logic [7:0] M_MIN  = 8'h7F;
  localparam logic [7:0] M_HOUR = 8'hBF;
  localparam logic [7:0] M_DATE = 8'h3F;
  localparam logic [7:0] M_MON  = 8'h1F;
  localparam logic [7:0] M_WDAY = 8'h07;
  localparam logic [7:0] M_YEAR = 8'hFF;

  // two-digit BCD increment with no wrap handling
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    else                return {v[7:4], v[3:0] + 4'h1};
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = en & ~clr;
    end else begin : g_cnt
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      assign tick = en && !clr && (cnt_q == LAST);

      always_ff @(posedge clk) begin
        if (rst || clr)     cnt_q <= '0;
        else if (en) begin
          if (cnt_q == LAST) cnt_q <= '0;
          else               cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len (
  input  logic [7:0] month,
  input  logic [7:0] year,
  output logic [7:0] last_date
);
  logic leap;
  logic [1:0] mod4;

  // (10*T + U) mod 4 == (2*T + U) mod 4
  assign mod4 = {year[4], 1'b0} + year[1:0];
  assign leap = (mod4 == 2'b00);

  always_comb begin
    unique case (month)
      8'h02:                      last_date = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
      default:                    last_date = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step (
  input  logic [7:0] hour_q,
  output logic [7:0] hour_n,
  output logic       day_carry
);
  import rtc_pkg::*;

  logic       mode12;
  logic       pm;
  logic [4:0] h12;
  logic [7:0] h24;
  logic [7:0] inc12;
  logic [7:0] inc24;

  assign mode12 = hour_q[7];
  assign pm     = hour_q[5];
  assign h12    = hour_q[4:0];
  assign h24    = {2'b00, hour_q[5:0]};
  assign inc12  = bcd_inc({3'b000, h12});
  assign inc24  = bcd_inc(h24);

  always_comb begin
    day_carry = 1'b0;
    if (!mode12) begin
      if (h24 == 8'h23) begin
        hour_n    = 8'h00;
        day_carry = 1'b1;
      end else begin
        hour_n = {2'b00, inc24[5:0]};
      end
    end else begin
      if (h12 == 5'h11) begin
        hour_n    = {1'b1, 1'b0, ~pm, 5'h12};
        day_carry = pm;
      end else if (h12 == 5'h12) begin
        hour_n = {1'b1, 1'b0, pm, 5'h01};
      end else begin
        hour_n = {1'b1, 1'b0, pm, inc12[4:0]};
      end
    end
  end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core (
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic [7:0] date_q,
  output logic [7:0] mon_q,
  output logic [7:0] wday_q,
  output logic [7:0] year_q
);
  import rtc_pkg::*;

  logic       sec_wrap, min_wrap, date_step, date_wrap, mon_step, mon_wrap;
  logic       hour_carry;
  logic [7:0] hour_nx;
  logic [7:0] last_date;

  rtc_hour_step u_hour (
    .hour_q   (hour_q),
    .hour_n   (hour_nx),
    .day_carry(hour_carry)
  );

  rtc_month_len u_mlen (
    .month    (mon_q),
    .year     (year_q),
    .last_date(last_date)
  );

  assign sec_wrap  = (sec_q[6:0] == 7'h59);
  assign min_wrap  = sec_wrap && (min_q == 8'h59);
  assign date_step = min_wrap && hour_carry;
  assign date_wrap = (date_q == last_date);
  assign mon_step  = date_step && date_wrap;
  assign mon_wrap  = (mon_q == 8'h12);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      wday_q <= 8'h01;
      year_q <= 8'h00;
    end else if (wr_en) begin
      unique case (reg_addr_e'(wr_addr))
        A_SEC:   sec_q  <= wr_data & M_SEC;
        A_MIN:   min_q  <= wr_data & M_MIN;
        A_HOUR:  hour_q <= wr_data & M_HOUR;
        A_DATE:  date_q <= wr_data & M_DATE;
        A_MON:   mon_q  <= wr_data & M_MON;
        A_WDAY:  wday_q <= wr_data & M_WDAY;
        A_YEAR:  year_q <= wr_data & M_YEAR;
        default: ;
      endcase
    end else if (step) begin
      sec_q <= sec_wrap ? 8'h00 : {1'b0, bcd_inc({1'b0, sec_q[6:0]})};
      if (sec_wrap)
        min_q <= (min_q == 8'h59) ? 8'h00 : bcd_inc(min_q);
      if (min_wrap)
        hour_q <= hour_nx;
      if (date_step) begin
        date_q <= date_wrap ? 8'h01 : bcd_inc(date_q);
        wday_q <= (wday_q == 8'h07) ? 8'h01 : wday_q + 8'h01;
      end
      if (mon_step)
        mon_q <= mon_wrap ? 8'h01 : bcd_inc(mon_q);
      if (mon_step && mon_wrap)
        year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
  parameter int DIV = 32768
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_tick,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data
);
  import rtc_pkg::*;

  logic       one_sec;
  logic       pre_clr;
  logic       halted;
  logic [7:0] sec_q, min_q, hour_q, date_q, mon_q, wday_q, year_q;

  assign halted  = sec_q[7];
  assign pre_clr = wr_en && (reg_addr_e'(wr_addr) == A_SEC);

  rtc_prescaler #(.DIV(DIV)) u_pre (
    .clk (clk),
    .rst (rst),
    .en  (ref_tick && !halted),
    .clr (pre_clr),
    .tick(one_sec)
  );

  rtc_time_core u_core (
    .clk    (clk),
    .rst    (rst),
    .step   (one_sec),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .sec_q  (sec_q),
    .min_q  (min_q),
    .hour_q (hour_q),
    .date_q (date_q),
    .mon_q  (mon_q),
    .wday_q (wday_q),
    .year_q (year_q)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= 8'h00;
    else begin
      unique case (reg_addr_e'(rd_addr))
        A_SEC:   rd_data <= sec_q;
        A_MIN:   rd_data <= min_q;
        A_HOUR:  rd_data <= hour_q;
        A_DATE:  rd_data <= date_q;
        A_MON:   rd_data <= mon_q;
        A_WDAY:  rd_data <= wday_q;
        A_YEAR:  rd_data <= year_q;
        default: rd_data <= 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic       clk,
  input logic       rst,
  input logic       ref_tick,
  input logic       wr_en,
  input logic [2:0] rd_addr,
  input logic [7:0] rd_data,
  input logic       one_sec,
  input logic [7:0] sec_q,
  input logic [7:0] min_q,
  input logic [7:0] hour_q,
  input logic [7:0] wday_q
);
  // R9: halted seconds register stays put unless written
  a_r9_halt_frozen: assert property (@(posedge clk) disable iff (rst)
    (sec_q[7] && !wr_en) |=> $stable(sec_q));

  // R10: a second step needs a reference enable and a running clock
  a_r10_step_source: assert property (@(posedge clk) disable iff (rst)
    one_sec |-> (ref_tick && !sec_q[7]));

  // R2: seconds and minutes stay in BCD range
  a_r2_sec_range: assert property (@(posedge clk) disable iff (rst)
    (sec_q[6:0] <= 7'h59) && (sec_q[3:0] <= 4'h9) && (min_q <= 8'h59));

  // R3: 24-hour value never exceeds 23
  a_r3_hour24_range: assert property (@(posedge clk) disable iff (rst)
    !hour_q[7] |-> (hour_q[5:0] <= 6'h23));

  // R8: weekday in 1..7
  a_r8_wday_range: assert property (@(posedge clk) disable iff (rst)
    (wday_q >= 8'h01) && (wday_q <= 8'h07));

  // R11: empty address reads zero one cycle later
  a_r11_empty_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == 3'd7) |=> (rd_data == 8'h00));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .ref_tick(ref_tick),
  .wr_en   (wr_en),
  .rd_addr (rd_addr),
  .rd_data (rd_data),
  .one_sec (one_sec),
  .sec_q   (sec_q),
  .min_q   (min_q),
  .hour_q  (hour_q),
  .wday_q  (wday_q)
);

// File: tb/rtc_calendar_bench.sv
`timescale 1ns/1ps
module rtc_calendar_bench;
  localparam int TB_DIV = 4;
  localparam int NVEC   = 16;

  // {start sec,min,hour,date,mon,wday,year , expected same order}
  localparam logic [111:0] VEC [NVEC] = '{
    {56'h59592331120799, 56'h00000001010100}, // R2 R3 R7 R8 full rollover
    {56'h59591915060310, 56'h00002015060310}, // R3 19 -> 20
    {56'h5959B130040205, 56'h00009201050305}, // R4 R5 11PM -> 12AM, Apr 30
    {56'h59599110030405, 56'h0000B210030405}, // R4 11AM -> 12PM
    {56'h5959B210030405, 56'h0000A110030405}, // R4 12PM -> 1PM
    {56'h59592328020124, 56'h00000029020224}, // R6 leap Feb 28
    {56'h59592329020224, 56'h00000001030324}, // R5 leap Feb 29
    {56'h59592328020523, 56'h00000001030623}, // R6 common Feb 28
    {56'h59592328020600, 56'h00000029020700}, // R6 year 00 leap
    {56'h59592328020712, 56'h00000029020112}, // R6 R8 year 12 leap
    {56'h59592330090150, 56'h00000001100250}, // R5 Sep 30
    {56'h59592331010150, 56'h00000001020250}, // R5 Jan 31
    {56'h09000001010100, 56'h10000001010100}, // R2 units carry
    {56'h59090001010100, 56'h00100001010100}, // R2 minute tens carry
    {56'h59599201010100, 56'h00008101010100}, // R4 12AM -> 1AM
    {56'h59592330110307, 56'h00000001120407}  // R5 Nov 30
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  rtc_calendar #(.DIV(TB_DIV)) u_rtc_calendar (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic refs(input int n);
    @(negedge clk);
    ref_tick = 1'b1;
    repeat (n) @(negedge clk);
    ref_tick = 1'b0;
  endtask

  task automatic load(input logic [55:0] t);
    for (int i = 6; i >= 0; i--) wr(3'(i), t[55-8*i -: 8]);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3'd0, v); chk("R1 sec", v, 8'h00);
    rd(3'd1, v); chk("R1 min", v, 8'h00);
    rd(3'd2, v); chk("R1 hour", v, 8'h00);
    rd(3'd3, v); chk("R1 date", v, 8'h01);
    rd(3'd4, v); chk("R1 month", v, 8'h01);
    rd(3'd5, v); chk("R1 wday", v, 8'h01);
    rd(3'd6, v); chk("R1 year", v, 8'h00);

    // vector table: load, one second, compare every field
    for (int k = 0; k < NVEC; k++) begin
      load(VEC[k][111:56]);
      refs(TB_DIV);
      for (int i = 0; i < 7; i++) begin
        rd(3'(i), v);
        chk($sformatf("R2-vector %0d field %0d", k, i), v, VEC[k][55-8*i -: 8]);
      end
    end

    // R11 masked bits, empty address
    wr(3'd5, 8'hFD); rd(3'd5, v); chk("R11 wday mask", v, 8'h05);
    wr(3'd2, 8'h52); rd(3'd2, v); chk("R11 hour bit6", v, 8'h12);
    wr(3'd0, 8'h33);
    wr(3'd7, 8'hFF); rd(3'd7, v); chk("R11 empty addr", v, 8'h00);
    rd(3'd0, v); chk("R11 write to 7 ignored", v, 8'h33);

    // R9 halt
    wr(3'd0, 8'hB0);
    refs(5 * TB_DIV);
    rd(3'd0, v); chk("R9 halted", v, 8'hB0);
    wr(3'd0, 8'h30);
    refs(TB_DIV);
    rd(3'd0, v); chk("R9 resumed", v, 8'h31);

    // R10 prescaler restart on seconds write
    wr(3'd0, 8'h10);
    refs(TB_DIV - 1);
    wr(3'd0, 8'h20);
    refs(TB_DIV - 1);
    rd(3'd0, v); chk("R10 before step", v, 8'h20);
    refs(1);
    rd(3'd0, v); chk("R10 at step", v, 8'h21);

    // R2 several seconds across a minute
    load(56'h55000001010100);
    refs(7 * TB_DIV);
    rd(3'd0, v); chk("R2 multi sec", v, 8'h02);
    rd(3'd1, v); chk("R2 multi min", v, 8'h01);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule